// File: doc/BRIEF.md
# Segment Dynamic Range Analyzer

This block sits between a wavelet transform and a bit-plane encoder. It takes a stream of signed 16-bit transform coefficients in fixed blocks of 64. Each block starts with one DC value, and the other 63 values are AC values. A fixed number of consecutive blocks forms a segment. While a segment streams in, the block builds three range figures as the coefficients arrive, without a second pass over stored data:

- the bit depth of the segment's DC values;
- the largest AC bit depth in the whole segment;
- the AC bit depth of each single block.

Coefficients are written into one half of a two-segment store. When the last coefficient of a segment is taken, that half is handed to the reader and the next segment fills the other half. The encoder can therefore start on a segment as soon as the segment closes. The reader sees a ready flag, the DC and segment AC depths of the oldest held segment, and a read port addressed by block and coefficient index. The read port returns the stored value and that block's AC depth one cycle later. A release pulse hands the oldest half back to the writer.

Top module: `seg_range_analyzer`

## Requirements
- R1: A coefficient is taken on a rising edge where `inValid` and `inReady` are both high. Index 0 of each 64-coefficient block is its DC value and indices 1 to 63 are AC values. A read at block b and index c of the oldest held segment returns, one cycle later, the value taken at that position.
- R2: A segment is `SEG_BLOCKS` consecutive blocks. `segReady` rises on the cycle after the last coefficient of a segment is taken, when no segment was held before.
- R3: `segDcDepth` equals the number of bits of the largest DC magnitude in the segment, plus one sign bit. A segment whose DC values are all zero gives 1, and a DC of -32768 gives 17.
- R4: `rdBlkAcDepth` gives, one cycle after the block index is presented, the number of bits of the largest AC magnitude in that block. It is 0 when all 63 AC values of the block are zero.
- R5: `segAcDepth` equals the largest per-block AC depth of the segment.
- R6: When two completed segments are held and none has been released, `inReady` is low. A value presented during that time is not taken.
- R7: A `segRelease` pulse while a segment is held frees the oldest segment. Outputs then refer to the next segment in arrival order. A release while nothing is held has no effect.
- R8: After reset `segReady` is low, `inReady` is high, and the first coefficient taken is the DC value of block 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input coefficient valid |
| inData | input | 16 | Signed coefficient |
| inReady | output | 1 | Block can take a coefficient |
| segReady | output | 1 | At least one completed segment is held |
| segDcDepth | output | 5 | DC bit depth of the oldest held segment |
| segAcDepth | output | 5 | Segment AC bit depth of the oldest held segment |
| rdBlock | input | $clog2(SEG_BLOCKS) | Block index for reads |
| rdCoef | input | 6 | Coefficient index within the block |
| rdData | output | 16 | Stored coefficient, one cycle after the address |
| rdBlkAcDepth | output | 5 | AC bit depth of `rdBlock`, one cycle after the address |
| segRelease | input | 1 | Single-cycle pulse freeing the oldest held segment |

## Verification
The assertions assume that `segRelease` is only a pulse and that the write stream follows the valid/ready rule. They also assume the read address is held steady for the cycle its result is awaited. The bench drives all inputs on the falling edge. It raises `inValid` only after it has seen `inReady` high, except in the one stall test, which deliberately presents a value against a full store. Releases in the bench are single-cycle pulses. One pulse is given with nothing held, to show that it changes nothing.

// File: rtl/sdr_pkg.sv
package sdr_pkg;
  localparam int COEF_W    = 16;
  localparam int BLK_COEFS = 64;
  localparam int COEF_IW   = $clog2(BLK_COEFS);
  localparam int DEPTH_W   = $clog2(COEF_W + 2);

  typedef struct packed {
    logic accept;
    logic isDc;
    logic blkEnd;
    logic segEnd;
    logic wrBuf;
  } strobe_t;

  function automatic logic [COEF_W-1:0] magOf(input logic [COEF_W-1:0] x);
    return x[COEF_W-1] ? (~x + 1'b1) : x;
  endfunction

  function automatic logic [DEPTH_W-1:0] bitsOf(input logic [COEF_W-1:0] v);
    logic [DEPTH_W-1:0] n;
    n = '0;
    for (int i = 0; i < COEF_W; i++)
      if (v[i]) n = DEPTH_W'(i + 1);
    return n;
  endfunction
endpackage

// File: rtl/sdr_ctrl.sv
module sdr_ctrl
  import sdr_pkg::*;
#(
  parameter int SEG_BLOCKS = 32,
  localparam int BLK_W = $clog2(SEG_BLOCKS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic               segRelease,
  output logic               inReady,
  output logic               segReady,
  output strobe_t            strb,
  output logic [BLK_W-1:0]   wrBlk,
  output logic [COEF_IW-1:0] wrCoef,
  output logic               rdBuf
);
  logic [1:0] occ;
  logic       wrBuf;
  logic       releaseOk;

  assign inReady   = (occ != 2'd2);
  assign segReady  = (occ != 2'd0);
  assign releaseOk = segRelease && (occ != 2'd0);

  always_comb begin
    strb.accept = inValid && inReady;
    strb.isDc   = (wrCoef == '0);
    strb.blkEnd = strb.accept && (wrCoef == COEF_IW'(BLK_COEFS - 1));
    strb.segEnd = strb.blkEnd && (wrBlk == BLK_W'(SEG_BLOCKS - 1));
    strb.wrBuf  = wrBuf;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      occ    <= '0;
      wrBuf  <= 1'b0;
      rdBuf  <= 1'b0;
      wrCoef <= '0;
      wrBlk  <= '0;
    end else begin
      if (strb.accept) begin
        wrCoef <= wrCoef + 1'b1;
        if (strb.blkEnd) wrBlk <= wrBlk + 1'b1;
        if (strb.segEnd) wrBuf <= ~wrBuf;
      end
      if (releaseOk) rdBuf <= ~rdBuf;
      case ({strb.segEnd, releaseOk})
        2'b10:   occ <= occ + 2'd1;
        2'b01:   occ <= occ - 2'd1;
        default: occ <= occ;
      endcase
    end
  end

  p_occ_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    occ <= 2'd2);
  p_seg_close_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.segEnd |=> segReady);
  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!inReady && !segRelease) |=> !inReady);
  p_release_last_r7: assert property (@(posedge clk) disable iff (!rstN)
    (segRelease && occ == 2'd1 && !strb.segEnd) |=> !segReady);
endmodule

// File: rtl/sdr_datapath.sv
module sdr_datapath
  import sdr_pkg::*;
#(
  parameter int SEG_BLOCKS = 32,
  localparam int BLK_W  = $clog2(SEG_BLOCKS),
  localparam int MEM_AW = 1 + BLK_W + COEF_IW,
  localparam int MEM_N  = 1 << MEM_AW
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  logic [BLK_W-1:0]   wrBlk,
  input  logic [COEF_IW-1:0] wrCoef,
  input  logic               rdBuf,
  input  logic [COEF_W-1:0]  inData,
  input  logic [BLK_W-1:0]   rdBlock,
  input  logic [COEF_IW-1:0] rdCoef,
  output logic [COEF_W-1:0]  rdData,
  output logic [DEPTH_W-1:0] rdBlkAcDepth,
  output logic [DEPTH_W-1:0] segDcDepth,
  output logic [DEPTH_W-1:0] segAcDepth
);
  logic [COEF_W-1:0]  coefMem [MEM_N];
  logic [DEPTH_W-1:0] blkDepthMem [2*SEG_BLOCKS];
  logic [DEPTH_W-1:0] dcDepthR [2];
  logic [DEPTH_W-1:0] acDepthR [2];
  logic [COEF_W-1:0]  dcOr, acBlkOr, acSegOr;
  logic [COEF_W-1:0]  mag, dcNext, acBlkNext, acSegNext;

  always_comb begin
    mag       = magOf(inData);
    dcNext    = dcOr    | (strb.isDc ? mag : '0);
    acBlkNext = acBlkOr | (strb.isDc ? '0 : mag);
    acSegNext = acSegOr | (strb.isDc ? '0 : mag);
  end

  always_ff @(posedge clk) begin
    if (strb.accept) coefMem[{strb.wrBuf, wrBlk, wrCoef}] <= inData;
    rdData <= coefMem[{rdBuf, rdBlock, rdCoef}];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dcOr    <= '0;
      acBlkOr <= '0;
      acSegOr <= '0;
      for (int b = 0; b < 2; b++) begin
        dcDepthR[b] <= '0;
        acDepthR[b] <= '0;
      end
      for (int k = 0; k < 2*SEG_BLOCKS; k++) blkDepthMem[k] <= '0;
      rdBlkAcDepth <= '0;
    end else begin
      rdBlkAcDepth <= blkDepthMem[{rdBuf, rdBlock}];
      if (strb.accept) begin
        if (strb.blkEnd) begin
          blkDepthMem[{strb.wrBuf, wrBlk}] <= bitsOf(acBlkNext);
          acBlkOr <= '0;
        end else begin
          acBlkOr <= acBlkNext;
        end
        if (strb.segEnd) begin
          dcDepthR[strb.wrBuf] <= bitsOf(dcNext) + 1'b1;
          acDepthR[strb.wrBuf] <= bitsOf(acSegNext);
          dcOr    <= '0;
          acSegOr <= '0;
        end else begin
          dcOr    <= dcNext;
          acSegOr <= acSegNext;
        end
      end
    end
  end

  assign segDcDepth = dcDepthR[rdBuf];
  assign segAcDepth = acDepthR[rdBuf];

  p_dc_nonzero_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.segEnd |=> dcDepthR[$past(strb.wrBuf)] != '0);
  p_blk_within_seg_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.blkEnd && !strb.segEnd) |=>
      blkDepthMem[{$past(strb.wrBuf), $past(wrBlk)}] <= bitsOf(acSegOr));
endmodule

// File: rtl/seg_range_analyzer.sv
module seg_range_analyzer
  import sdr_pkg::*;
#(
  parameter int SEG_BLOCKS = 32,
  localparam int BLK_W = $clog2(SEG_BLOCKS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [COEF_W-1:0]  inData,
  output logic               inReady,
  output logic               segReady,
  output logic [DEPTH_W-1:0] segDcDepth,
  output logic [DEPTH_W-1:0] segAcDepth,
  input  logic [BLK_W-1:0]   rdBlock,
  input  logic [COEF_IW-1:0] rdCoef,
  output logic [COEF_W-1:0]  rdData,
  output logic [DEPTH_W-1:0] rdBlkAcDepth,
  input  logic               segRelease
);
  strobe_t            strb;
  logic [BLK_W-1:0]   wrBlk;
  logic [COEF_IW-1:0] wrCoef;
  logic               rdBuf;

  sdr_ctrl #(.SEG_BLOCKS(SEG_BLOCKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .segRelease(segRelease),
    .inReady(inReady), .segReady(segReady), .strb(strb),
    .wrBlk(wrBlk), .wrCoef(wrCoef), .rdBuf(rdBuf)
  );

  sdr_datapath #(.SEG_BLOCKS(SEG_BLOCKS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrBlk(wrBlk), .wrCoef(wrCoef),
    .rdBuf(rdBuf), .inData(inData), .rdBlock(rdBlock), .rdCoef(rdCoef),
    .rdData(rdData), .rdBlkAcDepth(rdBlkAcDepth),
    .segDcDepth(segDcDepth), .segAcDepth(segAcDepth)
  );

  p_depth_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    segReady |-> (segDcDepth >= 1 && segDcDepth <= 17 && segAcDepth <= 16));
endmodule

// File: tb/seg_range_analyzer_bench.sv
module seg_range_analyzer_bench;
  localparam int SB = 32;
  localparam int BW = $clog2(SB);

  logic clk = 0, rstN = 0, inValid = 0, segRelease = 0;
  logic [15:0] inData = 0;
  logic [BW-1:0] rdBlock = 0;
  logic [5:0] rdCoef = 0;
  logic inReady, segReady;
  logic [4:0] segDcDepth, segAcDepth, rdBlkAcDepth;
  logic [15:0] rdData;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  seg_range_analyzer #(.SEG_BLOCKS(SB)) u_seg_range_analyzer (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .inReady(inReady), .segReady(segReady), .segDcDepth(segDcDepth),
    .segAcDepth(segAcDepth), .rdBlock(rdBlock), .rdCoef(rdCoef),
    .rdData(rdData), .rdBlkAcDepth(rdBlkAcDepth), .segRelease(segRelease)
  );

  // pattern table: {dcAmp, acAmp}; pattern 3 also forces DC -32768 in block 0
  localparam int NPAT = 4;
  localparam int PAT [NPAT][2] = '{'{0, 0}, '{100, 1000}, '{32767, 5}, '{32767, 32767}};

  function automatic logic [15:0] coefVal(int p, int b, int c);
    int v;
    if (c == 0) begin
      if (p == 3 && b == 0) return 16'h8000;
      v = (b * 37 + p) % (PAT[p][0] + 1);
      if (b % 2 == 1) v = -v;
    end else begin
      if (b % 4 == 2) return 16'h0000;
      v = (b * 13 + c * 7 + p) % ((PAT[p][1] >> (b % 5)) + 1);
      if (c % 2 == 1) v = -v;
    end
    return 16'(v);
  endfunction

  function automatic int depthOf(int m);
    int n = 0;
    while ((m >> n) != 0) n++;
    return n;
  endfunction

  function automatic int absOf(logic [15:0] x);
    return x[15] ? 65536 - int'(x) : int'(x);
  endfunction

  function automatic int expBlk(int p, int b);
    int m = 0;
    for (int c = 1; c < 64; c++) if (absOf(coefVal(p, b, c)) > m) m = absOf(coefVal(p, b, c));
    return depthOf(m);
  endfunction

  function automatic int expDc(int p);
    int m = 0;
    for (int b = 0; b < SB; b++) if (absOf(coefVal(p, b, 0)) > m) m = absOf(coefVal(p, b, 0));
    return depthOf(m) + 1;
  endfunction

  function automatic int expAc(int p);
    int m = 0;
    for (int b = 0; b < SB; b++) if (expBlk(p, b) > m) m = expBlk(p, b);
    return m;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sendSeg(int p, int startCoef);
    for (int b = 0; b < SB; b++)
      for (int c = 0; c < 64; c++) begin
        if (b == 0 && c < startCoef) continue;
        while (!inReady) @(negedge clk);
        inValid = 1; inData = coefVal(p, b, c);
        @(negedge clk);
        inValid = 0;
      end
  endtask

  task automatic readAt(int b, int c);
    rdBlock = BW'(b); rdCoef = 6'(c);
    @(negedge clk); @(negedge clk);
  endtask

  task automatic pulseRelease();
    segRelease = 1; @(negedge clk); segRelease = 0; @(negedge clk);
  endtask

  task automatic checkSeg(int p);
    check("R3 dc depth", segDcDepth, expDc(p));
    check("R5 seg ac depth", segAcDepth, expAc(p));
    for (int b = 0; b < SB; b++) begin
      readAt(b, (b * 11) % 64);
      check("R4 block ac depth", rdBlkAcDepth, expBlk(p, b));
      check("R1 readback", rdData, coefVal(p, b, (b * 11) % 64));
    end
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1; @(negedge clk);
    check("R8 segReady after reset", segReady, 0);
    check("R8 inReady after reset", inReady, 1);

    // table walk: one segment per pattern
    for (int p = 0; p < NPAT; p++) begin
      sendSeg(p, 0);
      check("R2 segReady after segment", segReady, 1);
      checkSeg(p);
      pulseRelease();
      check("R7 released single", segReady, 0);
    end
    check("R3 all-zero dc gives 1", expDc(0), 1);
    check("R3 -32768 gives 17", expDc(3), 17);

    // R2: one coefficient short of a segment does not raise segReady
    for (int b = 0; b < SB; b++)
      for (int c = 0; c < 64; c++) begin
        if (b == SB - 1 && c == 63) break;
        inValid = 1; inData = coefVal(1, b, c); @(negedge clk);
      end
    inValid = 0;
    check("R2 not ready before last", segReady, 0);
    inValid = 1; inData = coefVal(1, SB - 1, 63); @(negedge clk); inValid = 0;
    check("R2 ready after last", segReady, 1);

    // R6: second segment fills store, input stalls
    sendSeg(2, 0);
    check("R6 stalled when full", inReady, 0);
    inValid = 1; inData = 16'h7abc;
    repeat (4) @(negedge clk);
    inValid = 0;
    check("R6 still stalled", inReady, 0);
    check("R7 oldest first dc", segDcDepth, expDc(1));
    checkSeg(1);
    pulseRelease();
    check("R6 ready after release", inReady, 1);
    check("R7 next segment held", segReady, 1);
    checkSeg(2);
    // the value offered while stalled must not have been taken: next segment starts at block 0 DC
    sendSeg(3, 0);
    pulseRelease();
    check("R6 stalled value ignored", segDcDepth, expDc(3));
    readAt(0, 0);
    check("R6 first stored coef", rdData, 16'h8000);
    pulseRelease();
    check("R7 drained", segReady, 0);

    // R7: release with nothing held has no effect
    pulseRelease();
    check("R7 empty release ignored", segReady, 0);
    sendSeg(1, 0);
    check("R7 after empty release", segReady, 1);
    checkSeg(1);
    pulseRelease();

    // R8: reset mid-segment restarts at block 0 DC
    sendSegPartial();
    rstN = 0; @(negedge clk); rstN = 1; @(negedge clk);
    check("R8 segReady after mid reset", segReady, 0);
    sendSeg(2, 0);
    check("R8 restart dc depth", segDcDepth, expDc(2));
    readAt(0, 0);
    check("R8 restart block0 dc", rdData, coefVal(2, 0, 0));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic sendSegPartial();
    for (int c = 0; c < 40; c++) begin
      inValid = 1; inData = 16'h1234; @(negedge clk);
    end
    inValid = 0;
  endtask
endmodule